// File: doc/BRIEF.md
# Remote terminal interrupt controller

This block gathers the interrupt events of a serial-bus remote terminal and drives two request lines to the host. One line carries message interrupts and the other carries hardware interrupts. Each event source delivers a single-cycle pulse. The block gates that pulse by an enable. If the pulse passes the gate, the block sets a pending bit that the host later clears by writing a one to it. An event that arrives while its type is disabled is dropped: it is not stored, and enabling the type afterwards never raises an interrupt for it.

There are two kinds of enable. Three message types use an enable bit taken from the descriptor of the subaddress being served. The descriptor bits arrive with the event. These three types are: zero-length execute, word available and broadcast received. Every other type uses only the host-written global enable register.

The block also holds a free-running time-tag counter, which advances on a tick input, and a host-loaded compare register. These produce two events: one when the counter rolls over and one when the counter matches the compare value.

Top module: `rt_irq_ctrl`

## Requirements
- R1: When a type's enable is 1 in the cycle its event pulse arrives, the pending bit of that type reads 1 from the next cycle on, and the line of that type reads 1 from the same cycle.
- R2: When a type's enable is 0 in the cycle its event arrives, the pending bit is unchanged and no line rises. Setting the enable later does not raise an interrupt for that event. If an enable write and an event fall in the same cycle, the enable value from before the write decides.
- R3: Zero-length execute (pending bit 0), word available (bit 1) and broadcast received (bit 2) are gated only by desc_en bits 0, 1 and 2, which are sampled with the event. Enable bits 0 to 2 always read 0, and writes to them are ignored.
- R4: Illegal command (bit 3) and message error (bit 4) are gated only by enable bits 3 and 4. The value of desc_en has no effect on them.
- R5: The pending and enable layout is as follows. Bit 5 is loopback fail on bus A and bit 6 is loopback fail on bus B. Bit 7 is SPI frame fault and bit 8 is RT address parity fault. Bit 9 is EEPROM checksum fault and bit 10 is RAM init fault. Bit 11 is time-tag rollover and bit 12 is time-tag match. msg_irq is 1 exactly when any of pending bits 0 to 4 is 1. hw_irq is 1 exactly when any of pending bits 5 to 12 is 1.
- R6: A write with pend_clr_we clears every pending bit whose pend_clr_data bit is 1 and leaves the other bits as they are. A line stays high while any of its pending bits remains 1. An event that passes its gate in the same cycle as a clear of its bit leaves that bit at 1.
- R7: After reset, pending reads 0, both lines read 0, tt_count reads 0, and the enable register reads 0x0600.
- R8: Enable bits 9 and 10 read 1 after reset and stay 1 whatever the host writes.
- R9: tt_count advances by one on each cycle with tt_tick high and holds otherwise. A tick taken at the all-ones value returns tt_count to 0 and raises the rollover event (bit 11).
- R10: The match event (bit 12) fires once, in the first cycle in which tt_count equals the compare value. It does not fire again while the counter holds at that value.
- R11: The loopback events of bus A and bus B are gated and latched separately. An event on one bus never sets the pending bit of the other bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_we | input | 1 | Write strobe for the global enable register |
| en_wdata | input | 13 | Value written to the enable register |
| pend_clr_we | input | 1 | Write-one-to-clear strobe for the pending register |
| pend_clr_data | input | 13 | Mask of pending bits to clear |
| cmp_we | input | 1 | Load strobe for the time-tag compare register |
| cmp_wdata | input | TT_W | Compare value |
| tt_tick | input | 1 | Advance enable for the time-tag counter |
| desc_en | input | 3 | Descriptor enables for the zero-length execute, word available and broadcast types |
| evt_xeqz | input | 1 | Zero-length execute event pulse |
| evt_wavail | input | 1 | Word available event pulse |
| evt_bcast | input | 1 | Broadcast received event pulse |
| evt_illcmd | input | 1 | Illegal command event pulse |
| evt_msgerr | input | 1 | Message error event pulse |
| evt_loop | input | 2 | Loopback mismatch pulses, bit 0 bus A, bit 1 bus B |
| evt_spi | input | 1 | SPI frame length fault pulse |
| evt_adrpar | input | 1 | RT address parity fault pulse |
| evt_eechk | input | 1 | EEPROM checksum fault pulse |
| evt_raminit | input | 1 | RAM init fault pulse |
| en_q | output | 13 | Current enable register |
| pend_q | output | 13 | Current pending register |
| msg_irq | output | 1 | Message interrupt line |
| hw_irq | output | 1 | Hardware interrupt line |
| tt_count | output | TT_W | Time-tag counter value |

## Verification
The bench builds the block with TT_W set to 8. This brings the rollover from all-ones back to zero within a few hundred cycles, so the bench can exercise the wrap event directly rather than only through the match. Holding the tick low then leaves the counter parked on the compare value, which is the situation where a repeat match would show. With the tick held low, the table of gating vectors runs without interference from the time-tag events.

// File: rtl/rt_irq_pkg.sv
package rt_irq_pkg;
  localparam int NTYPES = 13;
  localparam int NDESC  = 3;

  localparam int IT_XEQZ    = 0;
  localparam int IT_WAVAIL  = 1;
  localparam int IT_BCAST   = 2;
  localparam int IT_ILLCMD  = 3;
  localparam int IT_MSGERR  = 4;
  localparam int IT_LOOPA   = 5;
  localparam int IT_LOOPB   = 6;
  localparam int IT_SPI     = 7;
  localparam int IT_ADRPAR  = 8;
  localparam int IT_EECHK   = 9;
  localparam int IT_RAMINIT = 10;
  localparam int IT_TTWRAP  = 11;
  localparam int IT_TTMATCH = 12;

  localparam logic [NTYPES-1:0] DESC_MASK   = 13'h0007;
  localparam logic [NTYPES-1:0] MSG_MASK    = 13'h001F;
  localparam logic [NTYPES-1:0] HW_MASK     = ~MSG_MASK;
  localparam logic [NTYPES-1:0] STICKY_MASK = 13'h0600;

  typedef logic [NTYPES-1:0] itype_vec_t;
endpackage

// File: rtl/rt_irq_rstsync.sv
module rt_irq_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/rt_irq_timetag.sv
module rt_irq_timetag #(
  parameter int TT_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            cmp_we,
  input  logic [TT_W-1:0] cmp_wdata,
  output logic [TT_W-1:0] count,
  output logic            wrap_evt,
  output logic            match_evt
);
  localparam logic [TT_W-1:0] CNT_MAX = {TT_W{1'b1}};

  logic [TT_W-1:0] count_q, count_nxt;
  logic [TT_W-1:0] cmp_q, cmp_nxt;
  logic            eq_q, eq_now;

  always_comb begin
    count_nxt = count_q;
    if (tick) count_nxt = count_q + 1'b1;
    cmp_nxt = cmp_q;
    if (cmp_we) cmp_nxt = cmp_wdata;
    eq_now = (count_q == cmp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      cmp_q   <= '0;
      eq_q    <= 1'b0;
    end else begin
      count_q <= count_nxt;
      cmp_q   <= cmp_nxt;
      eq_q    <= eq_now;
    end
  end

  assign count     = count_q;
  assign wrap_evt  = tick && (count_q == CNT_MAX);
  assign match_evt = eq_now && !eq_q;
endmodule

// File: rtl/rt_irq_gate.sv
module rt_irq_gate
  import rt_irq_pkg::*;
(
  input  itype_vec_t       raw_evt,
  input  logic [NDESC-1:0] desc_en,
  input  itype_vec_t       en_q,
  output itype_vec_t       set_vec
);
  for (genvar i = 0; i < NTYPES; i++) begin : g_type
    if (DESC_MASK[i]) begin : g_desc
      assign set_vec[i] = raw_evt[i] & desc_en[i];
    end else begin : g_glob
      assign set_vec[i] = raw_evt[i] & en_q[i];
    end
  end
endmodule

// File: rtl/rt_irq_regs.sv
module rt_irq_regs
  import rt_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_we,
  input  itype_vec_t en_wdata,
  input  logic       pend_clr_we,
  input  itype_vec_t pend_clr_data,
  input  itype_vec_t set_vec,
  output itype_vec_t en_q,
  output itype_vec_t pend_q
);
  itype_vec_t en_r, en_nxt, pend_r, pend_nxt, clr_mask;

  always_comb begin
    en_nxt = en_r;
    if (en_we) en_nxt = (en_wdata & ~DESC_MASK) | STICKY_MASK;
    clr_mask = pend_clr_we ? pend_clr_data : '0;
    pend_nxt = (pend_r & ~clr_mask) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r   <= STICKY_MASK;
      pend_r <= '0;
    end else begin
      en_r   <= en_nxt;
      pend_r <= pend_nxt;
    end
  end

  assign en_q   = en_r;
  assign pend_q = pend_r;
endmodule

// File: rtl/rt_irq_ctrl.sv
module rt_irq_ctrl
  import rt_irq_pkg::*;
#(
  parameter int TT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_we,
  input  logic [NTYPES-1:0]    en_wdata,
  input  logic                 pend_clr_we,
  input  logic [NTYPES-1:0]    pend_clr_data,
  input  logic                 cmp_we,
  input  logic [TT_W-1:0]      cmp_wdata,
  input  logic                 tt_tick,
  input  logic [NDESC-1:0]     desc_en,
  input  logic                 evt_xeqz,
  input  logic                 evt_wavail,
  input  logic                 evt_bcast,
  input  logic                 evt_illcmd,
  input  logic                 evt_msgerr,
  input  logic [1:0]           evt_loop,
  input  logic                 evt_spi,
  input  logic                 evt_adrpar,
  input  logic                 evt_eechk,
  input  logic                 evt_raminit,
  output logic [NTYPES-1:0]    en_q,
  output logic [NTYPES-1:0]    pend_q,
  output logic                 msg_irq,
  output logic                 hw_irq,
  output logic [TT_W-1:0]      tt_count
);
  logic       rst_n_sync;
  logic       tt_wrap, tt_match;
  itype_vec_t raw_evt, set_vec;

  rt_irq_rstsync u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  rt_irq_timetag #(.TT_W(TT_W)) u_timetag (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .tick      (tt_tick),
    .cmp_we    (cmp_we),
    .cmp_wdata (cmp_wdata),
    .count     (tt_count),
    .wrap_evt  (tt_wrap),
    .match_evt (tt_match)
  );

  always_comb begin
    raw_evt             = '0;
    raw_evt[IT_XEQZ]    = evt_xeqz;
    raw_evt[IT_WAVAIL]  = evt_wavail;
    raw_evt[IT_BCAST]   = evt_bcast;
    raw_evt[IT_ILLCMD]  = evt_illcmd;
    raw_evt[IT_MSGERR]  = evt_msgerr;
    raw_evt[IT_LOOPA]   = evt_loop[0];
    raw_evt[IT_LOOPB]   = evt_loop[1];
    raw_evt[IT_SPI]     = evt_spi;
    raw_evt[IT_ADRPAR]  = evt_adrpar;
    raw_evt[IT_EECHK]   = evt_eechk;
    raw_evt[IT_RAMINIT] = evt_raminit;
    raw_evt[IT_TTWRAP]  = tt_wrap;
    raw_evt[IT_TTMATCH] = tt_match;
  end

  rt_irq_gate u_gate (
    .raw_evt (raw_evt),
    .desc_en (desc_en),
    .en_q    (en_q),
    .set_vec (set_vec)
  );

  rt_irq_regs u_regs (
    .clk           (clk),
    .rst_n         (rst_n_sync),
    .en_we         (en_we),
    .en_wdata      (en_wdata),
    .pend_clr_we   (pend_clr_we),
    .pend_clr_data (pend_clr_data),
    .set_vec       (set_vec),
    .en_q          (en_q),
    .pend_q        (pend_q)
  );

  assign msg_irq = |(pend_q & MSG_MASK);
  assign hw_irq  = |(pend_q & HW_MASK);
endmodule

// File: rtl/rt_irq_chk.sv
module rt_irq_chk
  import rt_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              en_we,
  input logic              pend_clr_we,
  input logic [NTYPES-1:0] pend_clr_data,
  input logic [NDESC-1:0]  desc_en,
  input logic              evt_xeqz,
  input logic              evt_bcast,
  input logic              evt_illcmd,
  input logic              evt_msgerr,
  input logic [1:0]        evt_loop,
  input logic              evt_spi,
  input logic [NTYPES-1:0] en_q,
  input logic [NTYPES-1:0] pend_q
);
  AST_EN_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    en_q[IT_SPI] && evt_spi |=> pend_q[IT_SPI]); // R1

  AST_OFF_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[IT_ILLCMD] && evt_illcmd && !pend_q[IT_ILLCMD] |=> !pend_q[IT_ILLCMD]); // R2

  AST_DESC_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_xeqz && !desc_en[IT_XEQZ] && !pend_q[IT_XEQZ] |=> !pend_q[IT_XEQZ]); // R3

  AST_DESC_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    evt_bcast && desc_en[IT_BCAST] |=> pend_q[IT_BCAST]); // R3

  AST_MSGERR_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    en_q[IT_MSGERR] && evt_msgerr |=> pend_q[IT_MSGERR]); // R4

  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q[IT_LOOPA] && !(pend_clr_we && pend_clr_data[IT_LOOPA]) |=> pend_q[IT_LOOPA]); // R6

  AST_STICKY_EN: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> en_q[IT_EECHK] && en_q[IT_RAMINIT]); // R8

  AST_BUS_SEPARATE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_loop == 2'b01 && !pend_q[IT_LOOPB] |=> !pend_q[IT_LOOPB]); // R11
endmodule

bind rt_irq_ctrl rt_irq_chk u_rt_irq_chk (
  .clk           (clk),
  .rst_n         (rst_n_sync),
  .en_we         (en_we),
  .pend_clr_we   (pend_clr_we),
  .pend_clr_data (pend_clr_data),
  .desc_en       (desc_en),
  .evt_xeqz      (evt_xeqz),
  .evt_bcast     (evt_bcast),
  .evt_illcmd    (evt_illcmd),
  .evt_msgerr    (evt_msgerr),
  .evt_loop      (evt_loop),
  .evt_spi       (evt_spi),
  .en_q          (en_q),
  .pend_q        (pend_q)
);

// File: tb/rt_irq_ctrl_bench.sv
`timescale 1ns/1ps
module rt_irq_ctrl_bench;
  localparam int TT_W = 8;
  localparam int NV   = 10;

  typedef struct packed {
    logic [12:0] en;
    logic [2:0]  desc;
    logic [12:0] ev;
    logic [12:0] exp;
  } vec_t;

  // R1 R2 R3 R4 R5 R11 gating vectors
  localparam vec_t VECS [NV] = '{
    '{13'h1FFF, 3'h7, 13'h07FF, 13'h07FF},
    '{13'h0000, 3'h0, 13'h07FF, 13'h0600},
    '{13'h0018, 3'h0, 13'h001F, 13'h0018},
    '{13'h0000, 3'h7, 13'h0007, 13'h0007},
    '{13'h1FFF, 3'h2, 13'h0007, 13'h0002},
    '{13'h0020, 3'h0, 13'h0060, 13'h0020},
    '{13'h0040, 3'h0, 13'h0060, 13'h0040},
    '{13'h0180, 3'h0, 13'h0080, 13'h0080},
    '{13'h0100, 3'h0, 13'h0180, 13'h0100},
    '{13'h1FF8, 3'h5, 13'h0005, 13'h0005}
  };

  logic clk, rst_n;
  logic en_we, pend_clr_we, cmp_we, tt_tick;
  logic [12:0] en_wdata, pend_clr_data;
  logic [TT_W-1:0] cmp_wdata, tt_count;
  logic [2:0] desc_en;
  logic evt_xeqz, evt_wavail, evt_bcast, evt_illcmd, evt_msgerr;
  logic [1:0] evt_loop;
  logic evt_spi, evt_adrpar, evt_eechk, evt_raminit;
  logic [12:0] en_q, pend_q;
  logic msg_irq, hw_irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [TT_W-1:0] c0;

  rt_irq_ctrl #(.TT_W(TT_W)) u_rt_irq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .en_we(en_we), .en_wdata(en_wdata),
    .pend_clr_we(pend_clr_we), .pend_clr_data(pend_clr_data),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .tt_tick(tt_tick),
    .desc_en(desc_en),
    .evt_xeqz(evt_xeqz), .evt_wavail(evt_wavail), .evt_bcast(evt_bcast),
    .evt_illcmd(evt_illcmd), .evt_msgerr(evt_msgerr), .evt_loop(evt_loop),
    .evt_spi(evt_spi), .evt_adrpar(evt_adrpar), .evt_eechk(evt_eechk),
    .evt_raminit(evt_raminit),
    .en_q(en_q), .pend_q(pend_q), .msg_irq(msg_irq), .hw_irq(hw_irq),
    .tt_count(tt_count)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_ev(input logic [12:0] ev, input logic [2:0] d);
    desc_en     = d;
    evt_xeqz    = ev[0];
    evt_wavail  = ev[1];
    evt_bcast   = ev[2];
    evt_illcmd  = ev[3];
    evt_msgerr  = ev[4];
    evt_loop    = ev[6:5];
    evt_spi     = ev[7];
    evt_adrpar  = ev[8];
    evt_eechk   = ev[9];
    evt_raminit = ev[10];
  endtask

  task automatic wr_en(input logic [12:0] v);
    @(negedge clk); en_we = 1'b1; en_wdata = v;
    @(negedge clk); en_we = 1'b0;
  endtask

  task automatic clr(input logic [12:0] m);
    @(negedge clk); pend_clr_we = 1'b1; pend_clr_data = m;
    @(negedge clk); pend_clr_we = 1'b0;
  endtask

  task automatic pulse(input logic [12:0] ev, input logic [2:0] d);
    @(negedge clk); drive_ev(ev, d);
    @(negedge clk); drive_ev(13'h0, 3'h0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en_we = 1'b0; pend_clr_we = 1'b0; cmp_we = 1'b0; tt_tick = 1'b0;
    en_wdata = '0; pend_clr_data = '0; cmp_wdata = '0;
    drive_ev(13'h0, 3'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7 reset state
    chk("R7 enable", {19'b0, en_q}, 32'h0600);
    chk("R7 pending", {19'b0, pend_q}, 32'h0);
    chk("R7 lines", {30'b0, msg_irq, hw_irq}, 32'h0);
    chk("R7 count", {24'b0, tt_count}, 32'h0);

    @(negedge clk); cmp_we = 1'b1; cmp_wdata = 8'h55;
    @(negedge clk); cmp_we = 1'b0;

    for (int i = 0; i < NV; i++) begin
      wr_en(VECS[i].en);
      clr(13'h1FFF);
      pulse(VECS[i].ev, VECS[i].desc);
      chk("R1/R2/R3/R4/R11 pending", {19'b0, pend_q}, {19'b0, VECS[i].exp});
      chk("R5 lines", {30'b0, msg_irq, hw_irq},
          {30'b0, |VECS[i].exp[4:0], |VECS[i].exp[12:5]});
    end

    // R8 sticky enables survive a write of zero
    wr_en(13'h0000);
    chk("R8 sticky", {19'b0, en_q}, 32'h0600);

    // R3 descriptor-type enable bits read 0
    wr_en(13'h0007);
    chk("R3 enable bits 0-2", {19'b0, en_q}, 32'h0600);

    // R2 late enable gives no interrupt
    clr(13'h1FFF);
    wr_en(13'h0000);
    pulse(13'h0080, 3'h0);
    wr_en(13'h0080);
    repeat (3) @(negedge clk);
    chk("R2 late enable", {31'b0, pend_q[7] | hw_irq}, 32'h0);

    // R2 enable write in the same cycle as the event
    wr_en(13'h0000);
    @(negedge clk); en_we = 1'b1; en_wdata = 13'h0080; drive_ev(13'h0080, 3'h0);
    @(negedge clk); en_we = 1'b0; drive_ev(13'h0, 3'h0);
    chk("R2 same-cycle enable", {31'b0, pend_q[7]}, 32'h0);

    // R6 write-one-to-clear and line hold
    wr_en(13'h00A0);
    pulse(13'h00A0, 3'h0);
    chk("R6 both set", {19'b0, pend_q}, 32'h00A0);
    clr(13'h0020);
    chk("R6 partial clear", {19'b0, pend_q, hw_irq}, {19'b0, 13'h0080, 1'b1});
    clr(13'h0080);
    chk("R6 line drops", {30'b0, hw_irq, |pend_q}, 32'h0);
    @(negedge clk); pend_clr_we = 1'b1; pend_clr_data = 13'h0080; drive_ev(13'h0080, 3'h0);
    @(negedge clk); pend_clr_we = 1'b0; drive_ev(13'h0, 3'h0);
    chk("R6 set wins over clear", {31'b0, pend_q[7]}, 32'h1);

    // R9 counting and rollover
    clr(13'h1FFF);
    wr_en(13'h0800);
    c0 = tt_count;
    tt_tick = 1'b1;
    repeat (3) @(negedge clk);
    tt_tick = 1'b0;
    chk("R9 advance", {24'b0, tt_count}, {24'b0, c0 + 8'd3});
    @(negedge clk); tt_tick = 1'b1;
    while (tt_count != 8'hFF) @(negedge clk);
    chk("R9 no early wrap", {31'b0, pend_q[11]}, 32'h0);
    @(negedge clk); tt_tick = 1'b0;
    chk("R9 wrap", {23'b0, tt_count, pend_q[11]}, {23'b0, 8'h00, 1'b1});

    // R10 match fires once
    clr(13'h1FFF);
    wr_en(13'h1000);
    c0 = tt_count;
    @(negedge clk); cmp_we = 1'b1; cmp_wdata = c0 + 8'd2;
    @(negedge clk); cmp_we = 1'b0; tt_tick = 1'b1;
    repeat (2) @(negedge clk);
    tt_tick = 1'b0;
    @(negedge clk);
    chk("R10 match", {31'b0, pend_q[12]}, 32'h1);
    clr(13'h1000);
    repeat (4) @(negedge clk);
    chk("R10 no refire", {31'b0, pend_q[12]}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule